// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells the front end of an out-of-order core which older in-flight store a newly fetched load or store should wait for. Instructions are grouped into store sets. A set-identifier table, indexed by a hash of the instruction word address, maps a load or store to a set number. A last-store table, indexed by set number, holds the tag of the youngest store fetched into that set. A fetched load with a set waits on that store. A fetched store also waits on it, and then becomes the youngest store of its set. Stores of one set are therefore chained in order, and a load ends up waiting, transitively, for every store of its set that is still in flight.

When the back end detects a memory-order violation, it reports the load and store word addresses. The predictor then places both in one set, merging two existing sets when necessary. When a store completes, it reports its address and tag, and the set's entry is released if that store is still the youngest of its set. A programmable cycle interval drives a small controller that periodically wipes every set assignment. This limits aliasing between unrelated code and stops merges from accumulating without end.

Top module: `ssp_dep_predictor`

Controller states: RUN (counting cycles) and FLUSH (one cycle in which the set-identifier table is wiped). Transitions: RUN→FLUSH when the interval is non-zero and the count has reached interval−1. FLUSH→RUN in every other case. FLUSH→FLUSH while the interval equals 1. RUN→RUN otherwise.

## Requirements
- R1: A fetched load or store whose table index has no valid set gets `dep_valid`=0 in the same cycle. Table index = XOR of the 10-bit slices of the 30-bit word address (low slice first, upper bits zero-padded).
- R2: A fetched load with a valid set gets `dep_valid`=1 and `dep_tag` equal to the set's youngest store tag when that entry is valid. Otherwise it gets `dep_valid`=0. The output is combinational in the fetch cycle.
- R3: A fetched store with a valid set reports the set's previous youngest store, as in R2. From the next cycle its own tag is the set's youngest store.
- R4: A fetched store with no valid set does not write the last-store table.
- R5: A violation where neither instruction has a set assigns both the set ID = index[6:0] XOR index[9:3] of the load, effective from the next cycle.
- R6: A violation where exactly one instruction has a set copies that set ID to the other one.
- R7: A violation where both have sets gives both the numerically smaller ID. The other members of the larger set keep their ID.
- R8: A completing store clears its set's last-store entry only if that entry holds the completing tag. A different tag leaves the entry unchanged.
- R9: If a store fetch and a completion address the same last-store entry in one cycle, the fetched store's tag is kept.
- R10: With interval N>0, the FLUSH state is entered in cycle N, counting the first cycle with a non-zero interval as cycle 0. From the cycle after FLUSH, every set assignment is invalid. The last-store table is untouched. N=0 never flushes. A violation in a FLUSH cycle is dropped.
- R11: After reset, no instruction has a set, no last-store entry is valid, and the controller is in RUN.
- R12: `dep_valid` is never 1 in a cycle without `fetch_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A load or store is fetched this cycle |
| fetch_is_store | input | 1 | 1 = store, 0 = load |
| fetch_pc | input | PC_W | Word address of the fetched instruction |
| fetch_tag | input | TAG_W | In-flight tag of the fetched instruction |
| dep_valid | output | 1 | The instruction must wait on a store |
| dep_tag | output | TAG_W | Tag of that store |
| done_valid | input | 1 | A store completed execution |
| done_pc | input | PC_W | Word address of the completed store |
| done_tag | input | TAG_W | Tag of the completed store |
| viol_valid | input | 1 | A memory-order violation is reported |
| viol_load_pc | input | PC_W | Word address of the violating load |
| viol_store_pc | input | PC_W | Word address of the offending store |
| clr_interval | input | CNT_W | Cycles between set-table wipes, 0 = never |

## Verification
The bench builds the block with its default sizes: 1024 set-identifier entries, 128 sets, 7-bit tags and 30-bit word addresses. Word addresses below 1024 map directly to table indices, so the set IDs produced by the hash can be chosen by hand. Two different addresses, 0x005 and 0x0A0, hash to sets 5 and 0x34, which makes a merge of two existing sets visible: the load that is moved follows the chain of set 5. The flush interval is a run-time input, so a short value of 10 brings the FLUSH transition into a test of a few dozen cycles, and the check can land exactly on the cycle of the wipe and the cycle after it.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic {
        CLR_RUN   = 1'b0,
        CLR_FLUSH = 1'b1
    } clr_state_e;

    typedef enum logic [1:0] {
        MRG_NEW      = 2'd0,
        MRG_TO_STORE = 2'd1,
        MRG_TO_LOAD  = 2'd2,
        MRG_SMALLER  = 2'd3
    } merge_kind_e;

endpackage

// File: rtl/ssp_pc_fold.sv
module ssp_pc_fold #(
    parameter int PC_W  = 30,
    parameter int IDX_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int N_SLICE = (PC_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W   = N_SLICE * IDX_W;

    logic [PAD_W-1:0] padded;

    generate
        if (PAD_W == PC_W) begin : g_exact
            assign padded = pc;
        end else begin : g_pad
            assign padded = {{(PAD_W - PC_W){1'b0}}, pc};
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int s = 0; s < N_SLICE; s++) begin
            idx = idx ^ padded[s*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
    parameter int ENTRIES = 1024,
    parameter int ID_W    = 7,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_f_idx,
    output logic             rd_f_v,
    output logic [ID_W-1:0]  rd_f_id,
    input  logic [IDX_W-1:0] rd_d_idx,
    output logic             rd_d_v,
    output logic [ID_W-1:0]  rd_d_id,
    input  logic [IDX_W-1:0] rd_l_idx,
    output logic             rd_l_v,
    output logic [ID_W-1:0]  rd_l_id,
    input  logic [IDX_W-1:0] rd_s_idx,
    output logic             rd_s_v,
    output logic [ID_W-1:0]  rd_s_id,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_l_idx,
    input  logic [IDX_W-1:0] wr_s_idx,
    input  logic [ID_W-1:0]  wr_id
);
    logic [ENTRIES-1:0] vld_q;
    logic [ID_W-1:0]    id_q [ENTRIES];

    // flush has priority over training in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_l_idx] <= 1'b1;
            vld_q[wr_s_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            id_q[wr_l_idx] <= wr_id;
            id_q[wr_s_idx] <= wr_id;
        end
    end

    assign rd_f_v  = vld_q[rd_f_idx];
    assign rd_f_id = id_q[rd_f_idx];
    assign rd_d_v  = vld_q[rd_d_idx];
    assign rd_d_id = id_q[rd_d_idx];
    assign rd_l_v  = vld_q[rd_l_idx];
    assign rd_l_id = id_q[rd_l_idx];
    assign rd_s_v  = vld_q[rd_s_idx];
    assign rd_s_id = id_q[rd_s_idx];
endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
    parameter int ENTRIES = 128,
    parameter int TAG_W   = 7,
    localparam int ID_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  rd_id,
    output logic             rd_v,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [ID_W-1:0]  clr_id,
    input  logic [TAG_W-1:0] clr_tag
);
    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic               clr_hit;

    assign clr_hit = clr_en && vld_q[clr_id] && (tag_q[clr_id] == clr_tag);

    // clear first, write after: a fetched store wins over a completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (clr_hit) begin
                vld_q[clr_id] <= 1'b0;
            end
            if (wr_en) begin
                vld_q[wr_id] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_id] <= wr_tag;
        end
    end

    assign rd_v   = vld_q[rd_id];
    assign rd_tag = tag_q[rd_id];
endmodule

// File: rtl/ssp_merge.sv
module ssp_merge
    import ssp_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int ID_W  = 7
) (
    input  logic             viol_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic             ld_v,
    input  logic [ID_W-1:0]  ld_id,
    input  logic             st_v,
    input  logic [ID_W-1:0]  st_id,
    output logic             wr_en,
    output logic [ID_W-1:0]  wr_id,
    output merge_kind_e      kind
);
    logic [ID_W-1:0] fresh_id;

    assign fresh_id = ld_idx[ID_W-1:0] ^ ld_idx[IDX_W-1 -: ID_W];

    always_comb begin
        unique case ({ld_v, st_v})
            2'b00:   kind = MRG_NEW;
            2'b10:   kind = MRG_TO_STORE;
            2'b01:   kind = MRG_TO_LOAD;
            default: kind = MRG_SMALLER;
        endcase
    end

    always_comb begin
        unique case (kind)
            MRG_NEW:      wr_id = fresh_id;
            MRG_TO_STORE: wr_id = ld_id;
            MRG_TO_LOAD:  wr_id = st_id;
            MRG_SMALLER:  wr_id = (ld_id < st_id) ? ld_id : st_id;
            default:      wr_id = fresh_id;
        endcase
    end

    assign wr_en = viol_valid;
endmodule

// File: rtl/ssp_clear_ctrl.sv
module ssp_clear_ctrl
    import ssp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval,
    output logic             flush
);
    clr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLR_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CLR_RUN: begin
                if (interval == '0) begin
                    cnt_d = '0;
                end else if (cnt_q >= interval - CNT_W'(1)) begin
                    state_d = CLR_FLUSH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            CLR_FLUSH: begin
                // the flush cycle is cycle 0 of the next period
                cnt_d   = CNT_W'(1);
                state_d = (interval == CNT_W'(1)) ? CLR_FLUSH : CLR_RUN;
            end
            default: begin
                state_d = CLR_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        flush = (state_q == CLR_FLUSH);
    end
endmodule

// File: rtl/ssp_dep_predictor.sv
module ssp_dep_predictor
    import ssp_pkg::*;
#(
    parameter int IDT_ENTRIES = 1024,
    parameter int LFT_ENTRIES = 128,
    parameter int TAG_W       = 7,
    parameter int PC_W        = 30,
    parameter int CNT_W       = 16,
    localparam int IDX_W      = $clog2(IDT_ENTRIES),
    localparam int ID_W       = $clog2(LFT_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic             fetch_is_store,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic [TAG_W-1:0] fetch_tag,
    output logic             dep_valid,
    output logic [TAG_W-1:0] dep_tag,
    input  logic             done_valid,
    input  logic [PC_W-1:0]  done_pc,
    input  logic [TAG_W-1:0] done_tag,
    input  logic             viol_valid,
    input  logic [PC_W-1:0]  viol_load_pc,
    input  logic [PC_W-1:0]  viol_store_pc,
    input  logic [CNT_W-1:0] clr_interval
);
    logic [IDX_W-1:0] f_idx, d_idx, vl_idx, vs_idx;
    logic             f_id_v, d_id_v, vl_v, vs_v;
    logic [ID_W-1:0]  f_id, d_id, vl_id, vs_id;
    logic             lf_v;
    logic [TAG_W-1:0] lf_tag;
    logic             flush;
    logic             mrg_wr_en;
    logic [ID_W-1:0]  mrg_wr_id;
    merge_kind_e      mrg_kind;

    ssp_pc_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fold_f (.pc(fetch_pc),      .idx(f_idx));
    ssp_pc_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fold_d (.pc(done_pc),       .idx(d_idx));
    ssp_pc_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fold_l (.pc(viol_load_pc),  .idx(vl_idx));
    ssp_pc_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fold_s (.pc(viol_store_pc), .idx(vs_idx));

    ssp_id_table #(.ENTRIES(IDT_ENTRIES), .ID_W(ID_W)) u_idt (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rd_f_idx (f_idx),
        .rd_f_v   (f_id_v),
        .rd_f_id  (f_id),
        .rd_d_idx (d_idx),
        .rd_d_v   (d_id_v),
        .rd_d_id  (d_id),
        .rd_l_idx (vl_idx),
        .rd_l_v   (vl_v),
        .rd_l_id  (vl_id),
        .rd_s_idx (vs_idx),
        .rd_s_v   (vs_v),
        .rd_s_id  (vs_id),
        .wr_en    (mrg_wr_en),
        .wr_l_idx (vl_idx),
        .wr_s_idx (vs_idx),
        .wr_id    (mrg_wr_id)
    );

    ssp_merge #(.IDX_W(IDX_W), .ID_W(ID_W)) u_merge (
        .viol_valid (viol_valid),
        .ld_idx     (vl_idx),
        .ld_v       (vl_v),
        .ld_id      (vl_id),
        .st_v       (vs_v),
        .st_id      (vs_id),
        .wr_en      (mrg_wr_en),
        .wr_id      (mrg_wr_id),
        .kind       (mrg_kind)
    );

    ssp_last_store #(.ENTRIES(LFT_ENTRIES), .TAG_W(TAG_W)) u_lft (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_id   (f_id),
        .rd_v    (lf_v),
        .rd_tag  (lf_tag),
        .wr_en   (fetch_valid && fetch_is_store && f_id_v),
        .wr_id   (f_id),
        .wr_tag  (fetch_tag),
        .clr_en  (done_valid && d_id_v),
        .clr_id  (d_id),
        .clr_tag (done_tag)
    );

    ssp_clear_ctrl #(.CNT_W(CNT_W)) u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (clr_interval),
        .flush    (flush)
    );

    assign dep_valid = fetch_valid && f_id_v && lf_v;
    assign dep_tag   = lf_tag;
endmodule

// File: rtl/ssp_dep_predictor_chk.sv
module ssp_dep_predictor_chk #(
    parameter int TAG_W = 7,
    parameter int PC_W  = 30,
    parameter int ID_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic             fetch_is_store,
    input logic [TAG_W-1:0] fetch_tag,
    input logic             dep_valid,
    input logic [TAG_W-1:0] dep_tag,
    input logic             viol_valid,
    input logic [PC_W-1:0]  viol_load_pc,
    input logic [PC_W-1:0]  viol_store_pc,
    input logic             flush,
    input logic             f_id_v,
    input logic [ID_W-1:0]  f_id,
    input logic             vl_v,
    input logic [ID_W-1:0]  vl_id,
    input logic             vs_v,
    input logic [ID_W-1:0]  vs_id
);
    // R12
    p_dep_needs_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> fetch_valid);

    // R10
    p_flush_wipes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dep_valid);

    // R5, R6, R7: after training, load and store share one valid set
    p_train_joins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !flush) |=>
            ((viol_load_pc != $past(viol_load_pc)) || (viol_store_pc != $past(viol_store_pc))
             || (vl_v && vs_v && (vl_id == vs_id))));

    // R3
    p_store_chains_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_is_store && f_id_v && !flush) |=>
            (!(fetch_valid && f_id_v && (f_id == $past(f_id)))
             || (dep_valid && (dep_tag == $past(fetch_tag)))));
endmodule

bind ssp_dep_predictor ssp_dep_predictor_chk #(
    .TAG_W (TAG_W),
    .PC_W  (PC_W),
    .ID_W  (ID_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid    (fetch_valid),
    .fetch_is_store (fetch_is_store),
    .fetch_tag      (fetch_tag),
    .dep_valid      (dep_valid),
    .dep_tag        (dep_tag),
    .viol_valid     (viol_valid),
    .viol_load_pc   (viol_load_pc),
    .viol_store_pc  (viol_store_pc),
    .flush          (flush),
    .f_id_v         (f_id_v),
    .f_id           (f_id),
    .vl_v           (vl_v),
    .vl_id          (vl_id),
    .vs_v           (vs_v),
    .vs_id          (vs_id)
);

// File: tb/ssp_dep_predictor_tb_top.sv
module ssp_dep_predictor_tb_top;
    localparam int TAG_W = 7;
    localparam int PC_W  = 30;
    localparam int CNT_W = 16;

    localparam logic [PC_W-1:0] LA = 30'h005;
    localparam logic [PC_W-1:0] LB = 30'h007;
    localparam logic [PC_W-1:0] LC = 30'h0A0;
    localparam logic [PC_W-1:0] SA = 30'h040;
    localparam logic [PC_W-1:0] SB = 30'h200;
    localparam logic [PC_W-1:0] SC = 30'h240;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fetch_valid = 1'b0, fetch_is_store = 1'b0;
    logic [PC_W-1:0]  fetch_pc = '0;
    logic [TAG_W-1:0] fetch_tag = '0;
    logic             dep_valid;
    logic [TAG_W-1:0] dep_tag;
    logic             done_valid = 1'b0;
    logic [PC_W-1:0]  done_pc = '0;
    logic [TAG_W-1:0] done_tag = '0;
    logic             viol_valid = 1'b0;
    logic [PC_W-1:0]  viol_load_pc = '0, viol_store_pc = '0;
    logic [CNT_W-1:0] clr_interval = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ssp_dep_predictor dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_is_store(fetch_is_store),
        .fetch_pc(fetch_pc), .fetch_tag(fetch_tag),
        .dep_valid(dep_valid), .dep_tag(dep_tag),
        .done_valid(done_valid), .done_pc(done_pc), .done_tag(done_tag),
        .viol_valid(viol_valid), .viol_load_pc(viol_load_pc), .viol_store_pc(viol_store_pc),
        .clr_interval(clr_interval)
    );

    task automatic check_dep(string req, logic exp_v, logic [TAG_W-1:0] exp_tag);
        n_checks++;
        if (dep_valid !== exp_v || (exp_v && dep_tag !== exp_tag)) begin
            n_errors++;
            $display("FAIL %s: actual dep_valid=%0b dep_tag=%0d, expected dep_valid=%0b dep_tag=%0d",
                     req, dep_valid, dep_tag, exp_v, exp_tag);
        end
    endtask

    // one cycle: drive at negedge, sample 1 ns later, release after the edge
    task automatic op(input logic fv, input logic fs, input logic [PC_W-1:0] fpc,
                      input logic [TAG_W-1:0] ftag,
                      input logic dv, input logic [PC_W-1:0] dpc, input logic [TAG_W-1:0] dtag,
                      input logic vv, input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] spc,
                      input bit chk, input logic exp_v, input logic [TAG_W-1:0] exp_tag,
                      input string req);
        @(negedge clk);
        fetch_valid = fv; fetch_is_store = fs; fetch_pc = fpc; fetch_tag = ftag;
        done_valid = dv; done_pc = dpc; done_tag = dtag;
        viol_valid = vv; viol_load_pc = lpc; viol_store_pc = spc;
        #1;
        if (chk) check_dep(req, exp_v, exp_tag);
        @(posedge clk);
        #1;
        fetch_valid = 1'b0; done_valid = 1'b0; viol_valid = 1'b0;
    endtask

    task automatic fetch(logic is_st, logic [PC_W-1:0] pc, logic [TAG_W-1:0] tag,
                         logic exp_v, logic [TAG_W-1:0] exp_tag, string req);
        op(1'b1, is_st, pc, tag, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, exp_v, exp_tag, req);
    endtask

    task automatic train(logic [PC_W-1:0] lpc, logic [PC_W-1:0] spc);
        op(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, lpc, spc, 1'b0, 1'b0, '0, "");
    endtask

    task automatic complete(logic [PC_W-1:0] pc, logic [TAG_W-1:0] tag);
        op(1'b0, 1'b0, '0, '0, 1'b1, pc, tag, 1'b0, '0, '0, 1'b0, 1'b0, '0, "");
    endtask

    task automatic t_reset_and_untrained();
        fetch(1'b0, LA, 7'd1, 1'b0, '0, "R11 load after reset");
        fetch(1'b1, SA, 7'd3, 1'b0, '0, "R1 store without set");
    endtask

    task automatic t_first_set();
        train(LA, SA);
        fetch(1'b1, SA, 7'd10, 1'b0, '0, "R4 untracked store left no entry");
        fetch(1'b1, SA, 7'd11, 1'b1, 7'd10, "R3 store chains to previous store");
        fetch(1'b0, LA, 7'd12, 1'b1, 7'd11, "R2 R5 load waits on youngest store");
        op(1'b0, 1'b0, LA, 7'd13, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 1'b0, '0, "R12 no fetch");
    endtask

    task automatic t_completion();
        complete(SA, 7'd10);
        fetch(1'b0, LA, 7'd14, 1'b1, 7'd11, "R8 stale tag ignored");
        complete(SA, 7'd11);
        fetch(1'b0, LA, 7'd15, 1'b0, '0, "R8 matching tag clears");
        fetch(1'b1, SA, 7'd20, 1'b0, '0, "R3 store into empty set");
        op(1'b1, 1'b1, SA, 7'd21, 1'b1, SA, 7'd20, 1'b0, '0, '0, 1'b1, 1'b1, 7'd20,
           "R9 same-cycle fetch and completion");
        fetch(1'b0, LA, 7'd22, 1'b1, 7'd21, "R9 fetched store kept");
    endtask

    task automatic t_copy();
        train(LA, SB);
        fetch(1'b1, SB, 7'd30, 1'b1, 7'd21, "R6 store copies load set");
        fetch(1'b0, LA, 7'd31, 1'b1, 7'd30, "R6 load sees copied store");
        train(LB, SA);
        fetch(1'b0, LB, 7'd32, 1'b1, 7'd30, "R6 load copies store set");
    endtask

    task automatic t_merge();
        train(LC, SC);
        fetch(1'b1, SC, 7'd40, 1'b0, '0, "R5 fresh set is distinct");
        fetch(1'b0, LC, 7'd41, 1'b1, 7'd40, "R5 fresh set chains");
        train(LC, SA);
        fetch(1'b0, LC, 7'd42, 1'b1, 7'd30, "R7 both take smaller id");
        fetch(1'b1, SC, 7'd43, 1'b1, 7'd40, "R7 other member keeps larger id");
    endtask

    task automatic t_flush();
        repeat (40) @(negedge clk);
        fetch(1'b0, LA, 7'd50, 1'b1, 7'd30, "R10 zero interval keeps sets");
        fetch(1'b1, SA, 7'd51, 1'b1, 7'd30, "R10 setup store");
        @(negedge clk);
        clr_interval = 16'd10;
        repeat (9) @(negedge clk);
        fetch(1'b0, LA, 7'd52, 1'b1, 7'd51, "R10 flush cycle still predicts");
        fetch(1'b0, LA, 7'd53, 1'b0, '0, "R10 sets wiped after flush");
        @(negedge clk);
        clr_interval = 16'd0;
        train(LA, SA);
        fetch(1'b0, LA, 7'd54, 1'b1, 7'd51, "R10 last-store table survives flush");
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_untrained();
        t_first_set();
        t_completion();
        t_copy();
        t_merge();
        t_flush();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule